// File: doc/BRIEF.md
# Three-Digit Start/Stop Stopwatch

A stopwatch core that keeps elapsed time as three cascaded decimal digits: tenths of a second, seconds and tens of seconds, covering 00.0 to 99.9 before wrapping. Everything runs on one fast system clock. A prescaler produces a single-cycle count enable every `TICK_DIV` cycles, and the lowest digit advances only on those pulses. No derived clock is used, so the block stays in one clock domain.

A single push-button input starts and stops the count. The button passes through a two-stage synchronizer. A rising-edge detector then turns each press into a one-cycle pulse that toggles an internal running flag. Holding the button down therefore counts as a single press. The active-low asynchronous reset clears the digits, the running flag and the prescaler. It is the only action outside the clock edge.

Each digit is presented as a 4-bit BCD value and as an active-low seven-segment pattern. Debouncing and display multiplexing are left to surrounding logic.

Top module: `stopwatch_core`

## Requirements
- R1: Each digit output is a 4-bit binary value in the range 0 to 9. While running, the tenths digit increases by exactly one on each count enable.
- R2: While running, count enables occur once every `TICK_DIV` system-clock cycles and last one cycle. Hence the tenths digit reads floor(running cycles / `TICK_DIV`) modulo 10.
- R3: The tenths digit wraps from 9 to 0 and carries one into the seconds digit. The seconds digit wraps from 9 to 0 and carries one into the tens digit.
- R4: From 99.9, the next count enable yields 00.0.
- R5: While `rst_ni` is low, all three digits read 0 without waiting for a clock edge. After reset the block is stopped and its prescaler count is cleared.
- R6: A rising edge of the synchronized `run_i` toggles the running flag. Holding `run_i` high for any number of cycles toggles it only once.
- R7: While stopped, the digits and the prescaler count hold. A change of `run_i` takes effect three clock edges after it is applied. The total count therefore equals floor(sum of the running intervals, each measured from the start press to the stop press, / `TICK_DIV`), with no tick lost or added at a resume.
- R8: Segment outputs are active-low. Bit 6 drives segment a and bit 0 drives segment g. The patterns are: 0=0000001, 1=1001111, 2=0010010, 3=0000110, 4=1001100, 5=0100100, 6=0100000, 7=0001111, 8=0000000, 9=0000100. Codes 10 to 15 give 1111111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Start/stop button, clean, asynchronous |
| tenths_o | output | 4 | Tenths-of-second digit, BCD |
| secs_o | output | 4 | Seconds digit, BCD |
| tens_o | output | 4 | Tens-of-seconds digit, BCD |
| seg_tenths_o | output | 7 | Active-low segments for the tenths digit |
| seg_secs_o | output | 7 | Active-low segments for the seconds digit |
| seg_tens_o | output | 7 | Active-low segments for the tens digit |

## Verification
The bench builds the block with `TICK_DIV` = 4 rather than ten million. This brings a full 1000-tick roll from 99.9 to 00.0 within a few thousand cycles. It also makes running intervals that are not multiples of the tick period cheap to string together. That exposes any lost or extra tick at a resume and any prescaler left uncleared by reset. A button held for dozens of cycles and a reset applied mid-period are also within reach at this setting.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int DIGITS = 3;
  localparam int BCD_W  = 4;
  localparam int SEG_W  = 7;
  localparam int DEC_MAX = 9;

  typedef logic [BCD_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0] seg_t;

  // active-low, bit 6 = segment a ... bit 0 = segment g
  function automatic seg_t bcd_to_seg(bcd_t d);
    seg_t s;
    case (d)
      4'd0:    s = 7'b0000001;
      4'd1:    s = 7'b1001111;
      4'd2:    s = 7'b0010010;
      4'd3:    s = 7'b0000110;
      4'd4:    s = 7'b1001100;
      4'd5:    s = 7'b0100100;
      4'd6:    s = 7'b0100000;
      4'd7:    s = 7'b0001111;
      4'd8:    s = 7'b0000000;
      4'd9:    s = 7'b0000100;
      default: s = 7'b1111111;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/sw_run_ctrl.sv
module sw_run_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic running_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         last_q;
  logic         running_q;
  logic         press;

  assign press = sync_q[MSB] & ~last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q    <= '0;
      last_q    <= 1'b0;
      running_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[MSB-1:0], btn_i};
      last_q <= sync_q[MSB];
      if (press) running_q <= ~running_q;
    end
  end

  assign running_o = running_q;

  // R6
  toggle_on_press_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press |=> running_q != $past(running_q));
  // R6
  no_press_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !press |=> $stable(running_q));
  // R6
  press_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press |=> !press);
endmodule

// File: rtl/sw_prescaler.sv
module sw_prescaler #(
  parameter int TICK_DIV = 10_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == LAST);
  assign tick_o  = en_i & at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (en_i)    cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
  end

  // R7
  hold_when_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
  // R2
  tick_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && TICK_DIV > 1) |=> !tick_o);
  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/sw_bcd_digit.sv
module sw_bcd_digit
  import sw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  output bcd_t digit_o,
  output logic carry_o
);
  bcd_t digit_q;
  logic at_max;

  assign at_max  = (digit_q == bcd_t'(DEC_MAX));
  assign carry_o = inc_i & at_max;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     digit_q <= '0;
    else if (inc_i)  digit_q <= at_max ? '0 : digit_q + bcd_t'(1);
  end

  assign digit_o = digit_q;

  // R1
  digit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digit_q <= bcd_t'(DEC_MAX));
  // R1
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !carry_o) |=> digit_q == $past(digit_q) + bcd_t'(1));
  // R3
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |=> digit_q == '0);
  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(digit_q));
endmodule

// File: rtl/sw_seg_dec.sv
module sw_seg_dec
  import sw_pkg::*;
(
  input  bcd_t bcd_i,
  output seg_t seg_o
);
  always_comb seg_o = bcd_to_seg(bcd_i);
endmodule

// File: rtl/stopwatch_core.sv
module stopwatch_core
  import sw_pkg::*;
#(
  parameter int TICK_DIV = 10_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  output logic [3:0] tenths_o,
  output logic [3:0] secs_o,
  output logic [3:0] tens_o,
  output logic [6:0] seg_tenths_o,
  output logic [6:0] seg_secs_o,
  output logic [6:0] seg_tens_o
);
  logic          running;
  logic          tick;
  logic [DIGITS:0] inc_w;
  bcd_t          digit_w [DIGITS];
  seg_t          seg_w   [DIGITS];

  sw_run_ctrl #(.SYNC_STAGES(2)) u_run (
    .clk_i(clk_i), .rst_ni(rst_ni), .btn_i(run_i), .running_o(running)
  );

  sw_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(running), .tick_o(tick)
  );

  assign inc_w[0] = tick;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    sw_bcd_digit u_dig (
      .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(inc_w[i]),
      .digit_o(digit_w[i]), .carry_o(inc_w[i+1])
    );
    sw_seg_dec u_seg (.bcd_i(digit_w[i]), .seg_o(seg_w[i]));
  end

  assign tenths_o     = digit_w[0];
  assign secs_o       = digit_w[1];
  assign tens_o       = digit_w[2];
  assign seg_tenths_o = seg_w[0];
  assign seg_secs_o   = seg_w[1];
  assign seg_tens_o   = seg_w[2];

  // R4
  full_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_w[DIGITS] |=> (tenths_o == '0 && secs_o == '0 && tens_o == '0));
  // R7
  stopped_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running |-> !tick);
endmodule

// File: tb/tb_stopwatch_core.sv
`timescale 1ns/100ps
module tb_stopwatch_core;
  localparam int DIV = 4;
  localparam int NV = 6;
  localparam int RUN_LEN [NV] = '{8, 14, 30, 400, 3544, 4};
  localparam int EXP_VAL [NV] = '{2, 5, 13, 113, 999, 0};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic run_i = 1'b0;
  logic [3:0] tenths_o, secs_o, tens_o;
  logic [6:0] seg_tenths_o, seg_secs_o, seg_tens_o;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  stopwatch_core #(.TICK_DIV(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run_i),
    .tenths_o(tenths_o), .secs_o(secs_o), .tens_o(tens_o),
    .seg_tenths_o(seg_tenths_o), .seg_secs_o(seg_secs_o), .seg_tens_o(seg_tens_o)
  );

  function automatic logic [6:0] seg_ref(int d);
    case (d)
      0: return 7'b0000001;  1: return 7'b1001111;
      2: return 7'b0010010;  3: return 7'b0000110;
      4: return 7'b1001100;  5: return 7'b0100100;
      6: return 7'b0100000;  7: return 7'b0001111;
      8: return 7'b0000000;  9: return 7'b0000100;
      default: return 7'b1111111;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_time(string req, int val);
    check({req, " tenths"}, int'(tenths_o), val % 10);
    check({req, " secs"},   int'(secs_o), (val / 10) % 10);
    check({req, " tens"},   int'(tens_o), (val / 100) % 10);
    check({req, " segs"}, int'({seg_tens_o, seg_secs_o, seg_tenths_o}),
          int'({seg_ref((val / 100) % 10), seg_ref((val / 10) % 10), seg_ref(val % 10)}));
  endtask

  task automatic press();
    run_i = 1'b1;
    repeat (2) @(negedge clk);
    run_i = 1'b0;
  endtask

  // start press to stop press spans len cycles
  task automatic run_for(int len);
    press();
    repeat (len - 2) @(negedge clk);
    press();
    repeat (8) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #900000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [3:0] t0, s0, d0;
    repeat (3) @(negedge clk);
    // R5 reset state, R8 pattern for zero
    check_time("R5 reset", 0);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk);
    check_time("R5 stopped after reset", 0);

    // R2 R3 R4 R7 R8: cumulative running intervals, remainders carried across resumes
    for (int i = 0; i < NV; i++) begin
      run_for(RUN_LEN[i]);
      check_time("R2/R3/R4/R7 table", EXP_VAL[i]);
    end

    // R7 frozen while stopped
    t0 = tenths_o; s0 = secs_o; d0 = tens_o;
    repeat (50) @(negedge clk);
    check("R7 frozen tenths", int'(tenths_o), int'(t0));
    check("R7 frozen secs", int'(secs_o), int'(s0));
    check("R7 frozen tens", int'(tens_o), int'(d0));

    // R6 held button toggles once: 60 running cycles -> 15 ticks
    run_i = 1'b1;
    repeat (40) @(negedge clk);
    run_i = 1'b0;
    repeat (20) @(negedge clk);
    press();
    repeat (8) @(negedge clk);
    check_time("R6 held press", 15);

    // R5 async reset mid-run, prescaler at 2
    press();
    repeat (23) @(negedge clk);
    #1 rst_ni = 1'b0;
    #1 check_time("R5 async clear", 0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (30) @(negedge clk);
    check_time("R5 stopped after mid-run reset", 0);
    // R5 prescaler cleared: 6 cycles -> 1 tick, not 2
    run_for(6);
    check_time("R5 prescaler cleared", 1);

    // R1 R3 one step at a time to 1.0
    for (int k = 2; k <= 10; k++) begin
      run_for(DIV);
      check("R1 step", int'(secs_o) * 10 + int'(tenths_o), k);
    end
    finish_up();
  end
endmodule